// File: doc/BRIEF.md
# Way-Partitioned Replacement Allocator for a Shared Cache Segment

This block decides where a new line is placed in one segment of a shared, set-associative last-level cache when several software domains compete for it. Every request names a domain (8-bit identifier, up to 256 domains) and says whether it is an instruction or a data access. On a miss, the block looks up the way mask that software has programmed for that domain and access kind. It walks the set's tree pseudo-LRU state and picks the least-recently-used way among the ways the mask allows. Hits are never restricted: any domain may hit in any way, and a hit only refreshes the recency state.

The mask table belongs to this segment instance alone. It can be rewritten while traffic is running. Lines that are already placed stay where they are, and only later fills follow the new mask. The highest identifier (255) is conventionally given to the on-chip I/O agent, and its masks are programmed the same way as any other domain's. The block records an owner for every line, which lets it keep an occupancy count per domain for monitoring. An empty mask is a programming error. In that case the block falls back to way 0 and raises a sticky error flag.

Top module: `qos_way_alloc`

## Requirements
- R1: After reset every mask (both kinds, all 256 domains) allows all ways, every occupancy count is 0, alloc_err is 0, and all recency state is cleared, so the first miss in any set with a full mask selects way 0.
- R2: On a miss (req_valid=1, req_hit=0), vic_way is always a way whose bit is set in the mask of req_dom for the access kind, where bit i of a mask enables way i.
- R3: Instruction fills (req_instr=1) use the instruction mask and data fills (req_instr=0) use the data mask; programming one leaves the other unchanged.
- R4: The recency state is a binary tree per set, in which each node points at its less recently used half. With a full mask, successive misses to a fresh set select ways 0, 4, 2, 6, 1, 5, 3, 7 and then 0 again.
- R5: With a partial mask, the tree walk follows each node's pointer unless that half has no allowed way, in which case it takes the other half.
- R6: A hit (req_valid=1, req_hit=1) in any way req_way is accepted regardless of masks, refreshes recency for that way, and changes no occupancy count.
- R7: A mask write (cfg_we=1) takes effect from the next cycle; a miss in the same cycle as the write uses the previous mask.
- R8: Domain 255, reserved for the I/O agent, has instruction and data masks that are written and obeyed like those of any other domain.
- R9: A miss whose mask is all zeros selects way 0 and sets alloc_err from the next cycle on; alloc_err then stays 1 until reset.
- R10: Each fill increments the count of the filling domain; if the replaced line was valid and owned by another domain, that domain's count decrements in the same cycle.
- R11: Rewriting a mask does not move or drop existing lines, so no occupancy count changes because of a mask write.
- R12: occ_count shows, in the same cycle, the occupancy count of the domain given on occ_sel_dom.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Mask write strobe |
| cfg_dom | input | 8 | Domain whose mask is written |
| cfg_instr | input | 1 | 1 writes the instruction mask, 0 the data mask |
| cfg_mask | input | 8 | New way mask, bit i enables way i |
| req_valid | input | 1 | Request present this cycle |
| req_hit | input | 1 | 1 for a hit, 0 for a miss that needs a victim |
| req_way | input | 3 | Way that hit (used when req_hit=1) |
| req_set | input | 4 | Set index of the request |
| req_dom | input | 8 | Domain identifier of the requester |
| req_instr | input | 1 | 1 for instruction access, 0 for data |
| vic_way | output | 3 | Chosen victim way for the current miss |
| alloc_err | output | 1 | Sticky flag: a miss found an empty mask |
| occ_sel_dom | input | 8 | Domain whose occupancy is shown |
| occ_count | output | 8 | Lines currently owned by occ_sel_dom |

## Verification
The properties assume that each request sets req_hit to say honestly whether a hit or miss occurred, and that a miss is followed at once by installing the fill in vic_way. They also assume that occ_sel_dom is held steady across cycles when occupancy is compared. The stimulus drives all requests and mask writes half a cycle away from the active edge. It holds each request for exactly one cycle, and it places the same-cycle write and miss case on a fresh set, so the old-mask rule can be seen in isolation. Each scenario uses its own set or domain, which keeps the expected tree pointers and counts derivable by hand.

// File: rtl/qos_pkg.sv
// Package: shared widths and the per-line ownership record of the allocator.
// Assumes an 8-bit domain identifier space.
package qos_pkg;
    localparam int DOM_W   = 8;
    localparam int NUM_DOM = 1 << DOM_W;

    typedef struct packed {
        logic             valid;
        logic [DOM_W-1:0] owner;
    } line_own_t;
endpackage

// File: rtl/qos_mask_table.sv
// Mask table: one way mask per domain and access kind for this segment.
// Read is combinational, so a write in the same cycle is seen only next cycle.
// Assumes nothing about write frequency.
module qos_mask_table
    import qos_pkg::*;
#(
    parameter int NUM_WAYS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DOM_W-1:0]    wr_dom,
    input  logic                wr_instr,
    input  logic [NUM_WAYS-1:0] wr_mask,
    input  logic [DOM_W-1:0]    rd_dom,
    input  logic                rd_instr,
    output logic [NUM_WAYS-1:0] rd_mask
);
    localparam int ENTRIES = 2 * NUM_DOM;

    logic [NUM_WAYS-1:0] tbl [ENTRIES];

    // Store masks; reset opens every way for every domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '1;
        end else if (wr_en) begin
            tbl[{wr_dom, wr_instr}] <= wr_mask;
        end
    end

    // Look up the mask for the current requester.
    assign rd_mask = tbl[{rd_dom, rd_instr}];
endmodule

// File: rtl/qos_plru_victim.sv
// Tree pseudo-LRU per set with mask-aware victim walk.
// Node n (heap order, 1-based) stored at bit n-1; 0 points left, 1 right.
// Assumes NUM_WAYS and NUM_SETS are powers of two.
module qos_plru_victim #(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_SETS)-1:0] rd_set,
    input  logic [NUM_WAYS-1:0]         allow_mask,
    input  logic                        upd_en,
    input  logic [$clog2(NUM_SETS)-1:0] upd_set,
    input  logic [$clog2(NUM_WAYS)-1:0] upd_way,
    output logic [$clog2(NUM_WAYS)-1:0] vic_way,
    output logic                        none_allowed
);
    localparam int LVL    = $clog2(NUM_WAYS);
    localparam int WAY_W  = LVL;
    localparam int NODE_W = LVL;

    logic [NUM_WAYS-2:0] tree [NUM_SETS];
    logic [NUM_WAYS-2:0] cur;
    logic [NUM_WAYS-2:0] nxt;
    logic [NUM_WAYS-1:0] ones;
    logic [NUM_WAYS-1:0] win;
    logic                left_any;
    logic                right_any;
    logic                go_right;
    int                  node;
    int                  lo;
    int                  half;
    int                  tn;

    assign ones         = '1;
    assign cur          = tree[rd_set];
    assign none_allowed = (allow_mask == '0);

    // Walk the tree from the root, steering away from halves with no allowed way.
    always_comb begin
        node      = 1;
        lo        = 0;
        half      = 0;
        win       = '0;
        left_any  = 1'b0;
        right_any = 1'b0;
        go_right  = 1'b0;
        for (int l = 0; l < LVL; l++) begin
            half      = NUM_WAYS >> (l + 1);
            win       = ones >> (NUM_WAYS - half);
            left_any  = |(allow_mask & (win << lo));
            right_any = |(allow_mask & (win << (lo + half)));
            go_right  = cur[NODE_W'(node - 1)] ? right_any : !left_any;
            if (go_right) lo = lo + half;
            node = 2 * node + (go_right ? 1 : 0);
        end
        vic_way = none_allowed ? '0 : WAY_W'(lo);
    end

    // Compute the touched tree: every node on the path points away from upd_way.
    always_comb begin
        nxt = tree[upd_set];
        tn  = 0;
        for (int l = 0; l < LVL; l++) begin
            tn = (1 << l) + (int'(upd_way) >> (LVL - l));
            nxt[NODE_W'(tn - 1)] = ~upd_way[WAY_W'(LVL - 1 - l)];
        end
    end

    // Hold recency state; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) tree[s] <= '0;
        end else if (upd_en) begin
            tree[upd_set] <= nxt;
        end
    end
endmodule

// File: rtl/qos_occupancy.sv
// Line ownership and per-domain occupancy counters.
// Assumes each fill is installed in the way reported for it.
module qos_occupancy
    import qos_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 16,
    parameter int CNT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_en,
    input  logic [$clog2(NUM_SETS)-1:0] fill_set,
    input  logic [$clog2(NUM_WAYS)-1:0] fill_way,
    input  logic [DOM_W-1:0]            fill_dom,
    input  logic [DOM_W-1:0]            mon_dom,
    output logic [CNT_W-1:0]            mon_count
);
    localparam int NUM_LINES = NUM_SETS * NUM_WAYS;

    line_own_t        own [NUM_LINES];
    logic [CNT_W-1:0] cnt [NUM_DOM];
    line_own_t        old;

    assign old = own[{fill_set, fill_way}];

    // Record the new owner of each filled line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) own[i] <= '0;
        end else if (fill_en) begin
            own[{fill_set, fill_way}] <= '{valid: 1'b1, owner: fill_dom};
        end
    end

    // Move one line of credit from the evicted owner to the filling domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < NUM_DOM; d++) cnt[d] <= '0;
        end else if (fill_en) begin
            if (!old.valid) begin
                cnt[fill_dom] <= cnt[fill_dom] + CNT_W'(1);
            end else if (old.owner != fill_dom) begin
                cnt[old.owner] <= cnt[old.owner] - CNT_W'(1);
                cnt[fill_dom]  <= cnt[fill_dom] + CNT_W'(1);
            end
        end
    end

    // Monitoring read port.
    assign mon_count = cnt[mon_dom];
endmodule

// File: rtl/qos_way_alloc.sv
// Top: way-partitioned victim selection for one shared-cache segment.
// Misses get a victim from the domain's mask and the set's recency tree;
// hits only refresh recency. Assumes the fill follows each miss at once.
module qos_way_alloc
    import qos_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [7:0]                  cfg_dom,
    input  logic                        cfg_instr,
    input  logic [NUM_WAYS-1:0]         cfg_mask,
    input  logic                        req_valid,
    input  logic                        req_hit,
    input  logic [$clog2(NUM_WAYS)-1:0] req_way,
    input  logic [$clog2(NUM_SETS)-1:0] req_set,
    input  logic [7:0]                  req_dom,
    input  logic                        req_instr,
    output logic [$clog2(NUM_WAYS)-1:0] vic_way,
    output logic                        alloc_err,
    input  logic [7:0]                  occ_sel_dom,
    output logic [$clog2(NUM_SETS*NUM_WAYS+1)-1:0] occ_count
);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int CNT_W = $clog2(NUM_SETS * NUM_WAYS + 1);

    logic [NUM_WAYS-1:0] cur_mask;
    logic                miss;
    logic                none_allowed;
    logic [WAY_W-1:0]    touch_way;

    assign miss      = req_valid && !req_hit;
    assign touch_way = req_hit ? req_way : vic_way;

    qos_mask_table #(.NUM_WAYS(NUM_WAYS)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_dom   (cfg_dom),
        .wr_instr (cfg_instr),
        .wr_mask  (cfg_mask),
        .rd_dom   (req_dom),
        .rd_instr (req_instr),
        .rd_mask  (cur_mask)
    );

    qos_plru_victim #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_plru (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_set       (req_set),
        .allow_mask   (cur_mask),
        .upd_en       (req_valid),
        .upd_set      (req_set),
        .upd_way      (touch_way),
        .vic_way      (vic_way),
        .none_allowed (none_allowed)
    );

    qos_occupancy #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .CNT_W(CNT_W)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (miss),
        .fill_set  (req_set),
        .fill_way  (vic_way),
        .fill_dom  (req_dom),
        .mon_dom   (occ_sel_dom),
        .mon_count (occ_count)
    );

    // Sticky flag for a miss that found no allowed way.
    always_ff @(posedge clk) begin
        if (!rst_n)                    alloc_err <= 1'b0;
        else if (miss && none_allowed) alloc_err <= 1'b1;
    end
endmodule

// File: rtl/qos_way_alloc_chk.sv
// Checker: temporal properties of the allocator, bound to the top module.
// Assumes occ_sel_dom is held steady when occupancy is compared.
module qos_way_alloc_chk #(
    parameter int NUM_WAYS = 8,
    parameter int CNT_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_hit,
    input logic [7:0]                  req_dom,
    input logic [NUM_WAYS-1:0]         cur_mask,
    input logic [$clog2(NUM_WAYS)-1:0] vic_way,
    input logic                        alloc_err,
    input logic [7:0]                  occ_sel_dom,
    input logic [CNT_W-1:0]            occ_count
);
    a_r2_victim_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && cur_mask != '0) |-> cur_mask[vic_way]);

    a_r9_empty_mask_way0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && cur_mask == '0) |-> (vic_way == '0));

    a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && cur_mask == '0) |=> alloc_err);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_err |=> alloc_err);

    // R6 and R11: without a fill no occupancy count moves.
    a_r11_occ_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_hit) |=>
            ($stable(occ_count) || occ_sel_dom != $past(occ_sel_dom)));

    a_r10_fill_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && req_dom == occ_sel_dom) |=>
            (occ_count >= $past(occ_count) || occ_sel_dom != $past(occ_sel_dom)));
endmodule

bind qos_way_alloc qos_way_alloc_chk #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_hit     (req_hit),
    .req_dom     (req_dom),
    .cur_mask    (cur_mask),
    .vic_way     (vic_way),
    .alloc_err   (alloc_err),
    .occ_sel_dom (occ_sel_dom),
    .occ_count   (occ_count)
);

// File: tb/tb_qos_way_alloc.sv
// Bench: vector table for recency order and hits, then directed mask cases.
module tb_qos_way_alloc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_dom = '0;
    logic       cfg_instr = 1'b0;
    logic [7:0] cfg_mask = '0;
    logic       req_valid = 1'b0;
    logic       req_hit = 1'b0;
    logic [2:0] req_way = '0;
    logic [3:0] req_set = '0;
    logic [7:0] req_dom = '0;
    logic       req_instr = 1'b0;
    logic [2:0] vic_way;
    logic       alloc_err;
    logic [7:0] occ_sel_dom = '0;
    logic [7:0] occ_count;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    qos_way_alloc dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dom(cfg_dom),
        .cfg_instr(cfg_instr), .cfg_mask(cfg_mask), .req_valid(req_valid),
        .req_hit(req_hit), .req_way(req_way), .req_set(req_set),
        .req_dom(req_dom), .req_instr(req_instr), .vic_way(vic_way),
        .alloc_err(alloc_err), .occ_sel_dom(occ_sel_dom), .occ_count(occ_count)
    );

    typedef struct packed {
        logic [3:0] set;
        logic [7:0] dom;
        logic       instr;
        logic       hit;
        logic [2:0] way;
        logic [2:0] expv;
    } vec_t;

    // R4 full-mask order on set 0, then an R6 hit, then a fill by another domain.
    localparam vec_t VEC [11] = '{
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd0},
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd4},
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd2},
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd6},
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd1},
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd5},
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd3},
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd7},
        '{4'd0, 8'd1, 1'b0, 1'b0, 3'd0, 3'd0},
        '{4'd0, 8'd1, 1'b0, 1'b1, 3'd4, 3'd0},
        '{4'd0, 8'd2, 1'b0, 1'b0, 3'd0, 3'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One request for one cycle; victim checked before the edge on a miss.
    task automatic do_req(input string tag, input logic [3:0] s, input logic [7:0] d,
                          input logic ins, input logic h, input logic [2:0] w,
                          input int exp);
        @(negedge clk);
        req_valid = 1'b1; req_set = s; req_dom = d; req_instr = ins;
        req_hit = h; req_way = w;
        #1;
        if (!h) check(tag, vic_way, exp);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] d, input logic ins, input logic [7:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dom = d; cfg_instr = ins; cfg_mask = m;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic chk_occ(input string tag, input logic [7:0] d, input int exp);
        @(negedge clk);
        occ_sel_dom = d;
        #1;
        check(tag, occ_count, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: state after reset.
        check("R1 alloc_err", alloc_err, 0);
        chk_occ("R1 occ dom0", 8'd0, 0);
        chk_occ("R12 occ dom1 empty", 8'd1, 0);

        // Table walk: R4 order, R6 hit, R10 eviction across domains.
        for (int i = 0; i < 11; i++) begin
            do_req(VEC[i].hit ? "R6 hit" : "R4 victim", VEC[i].set, VEC[i].dom,
                   VEC[i].instr, VEC[i].hit, VEC[i].way, int'(VEC[i].expv));
            if (i == 9) chk_occ("R6 hit keeps occ", 8'd1, 8);
        end
        chk_occ("R10 evicted owner", 8'd1, 7);
        chk_occ("R10 filler", 8'd2, 1);

        // R2/R5: data mask {6,7} for domain 3 on fresh set 1.
        wr_mask(8'd3, 1'b0, 8'hC0);
        do_req("R5 masked walk", 4'd1, 8'd3, 1'b0, 1'b0, 3'd0, 6);
        do_req("R5 masked walk", 4'd1, 8'd3, 1'b0, 1'b0, 3'd0, 7);
        do_req("R2 in mask", 4'd1, 8'd3, 1'b0, 1'b0, 3'd0, 6);
        // R3: instruction mask of domain 3 still full.
        do_req("R3 instr mask", 4'd1, 8'd3, 1'b1, 1'b0, 3'd0, 0);
        chk_occ("R10 own evict", 8'd3, 3);
        // R11: mask rewrite leaves occupancy alone.
        wr_mask(8'd3, 1'b0, 8'h01);
        chk_occ("R11 rewrite keeps occ", 8'd3, 3);

        // R7: same-cycle write and miss use the old mask.
        @(negedge clk);
        cfg_we = 1'b1; cfg_dom = 8'd4; cfg_instr = 1'b0; cfg_mask = 8'h02;
        req_valid = 1'b1; req_hit = 1'b0; req_set = 4'd2; req_dom = 8'd4; req_instr = 1'b0;
        #1;
        check("R7 old mask", vic_way, 0);
        @(posedge clk);
        #1;
        cfg_we = 1'b0; req_valid = 1'b0;
        do_req("R7 new mask", 4'd2, 8'd4, 1'b0, 1'b0, 3'd0, 1);

        // R8: I/O domain 255.
        wr_mask(8'd255, 1'b1, 8'h10);
        do_req("R8 io instr", 4'd3, 8'd255, 1'b1, 1'b0, 3'd0, 4);
        do_req("R8 io data", 4'd3, 8'd255, 1'b0, 1'b0, 3'd0, 0);

        // R9: empty mask falls back to way 0 and sets a sticky error.
        check("R9 err before", alloc_err, 0);
        wr_mask(8'd5, 1'b0, 8'h00);
        do_req("R9 way0", 4'd4, 8'd5, 1'b0, 1'b0, 3'd0, 0);
        check("R9 err set", alloc_err, 1);
        do_req("R9 normal miss", 4'd5, 8'd6, 1'b0, 1'b0, 3'd0, 0);
        check("R9 err sticky", alloc_err, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule